// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every memory access a processor core makes, whether the physical address may be touched at the current privilege level. It holds a table of protection regions. Each region has a small configuration byte and an address register. The configuration byte holds separate read, write and execute grants, an address-match mode and a lock flag. Software programs the table through a one-entry-per-cycle register-write port. The core presents a word address, the access kind and the privilege level. The block then raises at most one access-fault flag: fetch, load or store.

Matching uses either a single naturally aligned 4-byte word or a naturally aligned power-of-two region. The region size is encoded by the trailing ones of the address register. When several regions cover the address, the one with the lowest index alone decides. An access that matches no region is refused at supervisor and user level and granted at machine level. Machine-level accesses are checked against a region's grants only when that region is locked. A locked region can no longer be rewritten until reset.

The check is combinational from the access inputs to the fault flags. This lets it sit directly after the virtual-memory permission stage. A refusal here wins over a grant from that stage. Only the region table is clocked.

Top module: `pmp_guard`

## Requirements
- R1: After reset every region is disabled, so a machine-level access (acc_priv=3) raises no fault and any supervisor or user access of kind fetch, load or store faults.
- R2: On a clock edge with wr_en=1, wr_sel=1 loads wr_data into the address register of region wr_idx, and wr_sel=0 loads wr_data[7:0] into its configuration byte; the fault outputs use the new value from the following cycle on.
- R3: The configuration byte layout is bit0 read, bit1 write, bit2 execute, bits[4:3] match mode, bit7 lock; bits 6 and 5 have no effect.
- R4: Match mode 0 and mode 1 match no address; mode 2 matches exactly the word whose word address acc_word equals the region's address register.
- R5: Match mode 3 treats an address register whose lowest t bits are ones (and bit t zero) as a region of 2^(t+3) bytes, starting at the register value with its lowest t+1 bits cleared, times 4.
- R6: When several regions match, only the lowest-numbered matching region decides the outcome.
- R7: For privilege values 0, 1 and 2 (user, supervisor, treated as supervisor), an access that matches no region faults.
- R8: A machine-level access faults only when the deciding region is locked; with no match or an unlocked match it is granted, whatever the grants are.
- R9: A locked deciding region applies its read, write and execute grants to machine-level accesses as well.
- R10: A region whose lock bit is set ignores writes to both its configuration byte and its address register, and keeps its lock until reset.
- R11: acc_kind 0 (fetch) needs execute, 1 (load) needs read, 2 (store) needs write, and 3 means no access; a refused access raises only the flag of its own kind, and kind 3 raises none.
- R12: The fault flags follow the access inputs within the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the region table |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table entry this cycle |
| wr_sel | input | 1 | 0 selects the configuration byte, 1 the address register |
| wr_idx | input | IDX_W (4) | Region index being written |
| wr_data | input | AR_W (30) | Write value; the configuration byte uses bits [7:0] |
| acc_word | input | AR_W (30) | Physical address of the access, bits [PA_W-1:2] |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 none |
| acc_priv | input | 2 | 0 user, 1 supervisor, 2 treated as supervisor, 3 machine |
| fault_fetch | output | 1 | Instruction fetch refused |
| fault_load | output | 1 | Load refused |
| fault_store | output | 1 | Store refused |

## Verification
On every cycle, the assertions check the following: at most one fault flag is raised, and it is of the presented kind. An idle access raises nothing. Machine level is refused only under a locked deciding region. An unmatched lower-privilege access faults. Locked entries stay frozen and locked, and unlocked address writes land. The reference model in the bench is needed for the other behaviours: the exact extent of power-of-two regions and single-word regions, the lowest-index priority among overlapping regions, the field positions inside the configuration byte, and the return to an unlocked, disabled table after a second reset.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    localparam int CFG_BYTE_W = 8;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_SPARE = 2'd1,
        MATCH_WORD  = 2'd2,
        MATCH_POW2  = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    typedef struct packed {
        logic        lock;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } region_cfg_t;

    typedef struct packed {
        logic lock;
        logic x;
        logic w;
        logic r;
    } region_perm_t;

    function automatic region_cfg_t unpack_cfg(input logic [CFG_BYTE_W-1:0] b);
        region_cfg_t c;
        c.r    = b[0];
        c.w    = b[1];
        c.x    = b[2];
        c.mode = match_mode_e'(b[4:3]);
        c.lock = b[7];
        return c;
    endfunction

endpackage

// File: rtl/pmp_region_bank.sv
module pmp_region_bank
    import pmp_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int AR_W  = 30,
    parameter int IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_sel,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [AR_W-1:0]            wr_data,
    output region_cfg_t [NREG-1:0]     cfg_q,
    output logic [NREG-1:0][AR_W-1:0]  addr_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        region_cfg_t     cfg_r;
        logic [AR_W-1:0] addr_r;
        logic            take;

        assign take = wr_en && (wr_idx == IDX_W'(g)) && !cfg_r.lock;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r  <= '0;
                addr_r <= '0;
            end else if (take) begin
                if (wr_sel) begin
                    addr_r <= wr_data;
                end else begin
                    cfg_r <= unpack_cfg(wr_data[CFG_BYTE_W-1:0]);
                end
            end
        end

        assign cfg_q[g]  = cfg_r;
        assign addr_q[g] = addr_r;
    end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_pkg::*;
#(
    parameter int AR_W = 30
) (
    input  match_mode_e     mode,
    input  logic [AR_W-1:0] base_reg,
    input  logic [AR_W-1:0] word,
    output logic            hit
);

    logic [AR_W-1:0] span;

    // ones from bit 0 up to and including the lowest zero of base_reg
    assign span = base_reg ^ (base_reg + AR_W'(1));

    always_comb begin
        unique case (mode)
            MATCH_WORD: hit = (word == base_reg);
            MATCH_POW2: hit = (((word ^ base_reg) & ~span) == '0);
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_priority_sel.sv
module pmp_priority_sel
    import pmp_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic [NREG-1:0]         hit,
    input  region_perm_t [NREG-1:0] perm,
    output logic                    sel_valid,
    output region_perm_t            sel_perm
);

    always_comb begin
        sel_valid = 1'b0;
        sel_perm  = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_valid = 1'b1;
                sel_perm  = perm[i];
            end
        end
    end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
    import pmp_pkg::*;
#(
    parameter int NREG = 16,
    parameter int PA_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_sel,
    input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] wr_idx,
    input  logic [PA_W-3:0]                     wr_data,
    input  logic [PA_W-3:0]                     acc_word,
    input  logic [1:0]                          acc_kind,
    input  logic [1:0]                          acc_priv,
    output logic                                fault_fetch,
    output logic                                fault_load,
    output logic                                fault_store
);

    localparam int AR_W  = PA_W - 2;
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    region_cfg_t [NREG-1:0]     cfg_q;
    logic [NREG-1:0][AR_W-1:0]  addr_q;
    logic [NREG-1:0]            hit;
    region_perm_t [NREG-1:0]    perm;
    logic                       sel_valid;
    region_perm_t               sel_perm;
    acc_kind_e                  kind_e;
    logic                       need;
    logic                       granted;
    logic                       denied;

    pmp_region_bank #(
        .NREG  (NREG),
        .AR_W  (AR_W),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .addr_q  (addr_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_region
        assign perm[g] = '{lock: cfg_q[g].lock, x: cfg_q[g].x,
                           w: cfg_q[g].w, r: cfg_q[g].r};

        pmp_region_match #(
            .AR_W (AR_W)
        ) u_match (
            .mode     (cfg_q[g].mode),
            .base_reg (addr_q[g]),
            .word     (acc_word),
            .hit      (hit[g])
        );
    end

    pmp_priority_sel #(
        .NREG (NREG)
    ) u_sel (
        .hit       (hit),
        .perm      (perm),
        .sel_valid (sel_valid),
        .sel_perm  (sel_perm)
    );

    assign kind_e = acc_kind_e'(acc_kind);

    always_comb begin
        unique case (kind_e)
            ACC_FETCH: need = sel_perm.x;
            ACC_LOAD:  need = sel_perm.r;
            ACC_STORE: need = sel_perm.w;
            default:   need = 1'b0;
        endcase

        if (acc_priv == PRIV_MACHINE) begin
            granted = !sel_valid || !sel_perm.lock || need;
        end else begin
            granted = sel_valid && need;
        end

        denied      = (kind_e != ACC_NONE) && !granted;
        fault_fetch = denied && (kind_e == ACC_FETCH);
        fault_load  = denied && (kind_e == ACC_LOAD);
        fault_store = denied && (kind_e == ACC_STORE);
    end

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk
    import pmp_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int AR_W  = 30,
    parameter int IDX_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      wr_sel,
    input logic [IDX_W-1:0]          wr_idx,
    input logic [AR_W-1:0]           wr_data,
    input logic [1:0]                acc_kind,
    input logic [1:0]                acc_priv,
    input logic                      fault_fetch,
    input logic                      fault_load,
    input logic                      fault_store,
    input logic                      sel_valid,
    input logic                      sel_lock,
    input region_cfg_t [NREG-1:0]    cfg_q,
    input logic [NREG-1:0][AR_W-1:0] addr_q
);

    logic any_fault;
    assign any_fault = fault_fetch || fault_load || fault_store;

    AST_SINGLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_fetch, fault_load, fault_store})); // R11

    AST_FETCH_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        fault_fetch |-> (acc_kind == 2'd0)); // R11

    AST_LOAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        fault_load |-> (acc_kind == 2'd1)); // R11

    AST_STORE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        fault_store |-> (acc_kind == 2'd2)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd3) |-> !any_fault); // R11

    AST_MACHINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_priv == PRIV_MACHINE) && !(sel_valid && sel_lock)) |-> !any_fault); // R8

    AST_LOWPRIV_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_priv != PRIV_MACHINE) && !sel_valid && (acc_kind != 2'd3)) |-> any_fault); // R7

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == IDX_W'(g)) && cfg_q[g].lock)
            |=> ((cfg_q[g] == $past(cfg_q[g])) && (addr_q[g] == $past(addr_q[g])))); // R10

        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g].lock |=> cfg_q[g].lock); // R10

        AST_ADDR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel && (wr_idx == IDX_W'(g)) && !cfg_q[g].lock)
            |=> (addr_q[g] == $past(wr_data))); // R2
    end

endmodule

bind pmp_guard pmp_guard_chk #(
    .NREG  (NREG),
    .AR_W  (AR_W),
    .IDX_W (IDX_W)
) u_pmp_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .acc_kind    (acc_kind),
    .acc_priv    (acc_priv),
    .fault_fetch (fault_fetch),
    .fault_load  (fault_load),
    .fault_store (fault_store),
    .sel_valid   (sel_valid),
    .sel_lock    (sel_perm.lock),
    .cfg_q       (cfg_q),
    .addr_q      (addr_q)
);

// File: tb/pmp_guard_test.sv
module pmp_guard_test;

    localparam int NREG  = 16;
    localparam int PA_W  = 32;
    localparam int AR_W  = PA_W - 2;
    localparam int IDX_W = 4;

    localparam int FETCH = 0, LOAD = 1, STORE = 2, IDLE = 3;
    localparam int PU = 0, PS = 1, PH = 2, PM = 3;
    localparam int CR = 8'h01, CW = 8'h02, CX = 8'h04;
    localparam int M_SPARE = 8'h08, M_WORD = 8'h10, M_POW2 = 8'h18, CLOCK = 8'h80;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [AR_W-1:0]  wr_data = '0;
    logic [AR_W-1:0]  acc_word = '0;
    logic [1:0]       acc_kind = 2'd3;
    logic [1:0]       acc_priv = 2'd3;
    logic             fault_fetch, fault_load, fault_store;

    int     checks = 0;
    int     failures = 0;
    int     m_cfg [NREG];
    longint m_addr[NREG];

    always #5 clk = ~clk;

    pmp_guard #(.NREG(NREG), .PA_W(PA_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .acc_word    (acc_word),
        .acc_kind    (acc_kind),
        .acc_priv    (acc_priv),
        .fault_fetch (fault_fetch),
        .fault_load  (fault_load),
        .fault_store (fault_store)
    );

    function automatic int trail_ones(longint v);
        int n = 0;
        while (n < AR_W && ((v >> n) & 1) == 1) n++;
        return n;
    endfunction

    // expected {store, load, fetch}
    function automatic logic [2:0] model(longint word, int kind, int priv);
        int hit = -1;
        bit need, grant;
        for (int i = 0; i < NREG; i++) begin
            if (hit < 0) begin
                int mode = (m_cfg[i] >> 3) & 3;
                if (mode == 2 && word == m_addr[i]) hit = i;
                if (mode == 3) begin
                    longint sz = longint'(1) << (trail_ones(m_addr[i]) + 1);
                    longint bs = m_addr[i] & ~(sz - 1);
                    if (word >= bs && word < bs + sz) hit = i;
                end
            end
        end
        if (kind == IDLE) return 3'b000;
        need = 1'b0;
        if (hit >= 0) begin
            if (kind == FETCH) need = m_cfg[hit][2];
            if (kind == LOAD)  need = m_cfg[hit][0];
            if (kind == STORE) need = m_cfg[hit][1];
        end
        if (priv == PM) grant = (hit < 0) || (m_cfg[hit][7] == 1'b0) || need;
        else            grant = (hit >= 0) && need;
        return grant ? 3'b000 : (3'b001 << kind);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NREG; i++) begin
            m_cfg[i]  = 0;
            m_addr[i] = 0;
        end
    endtask

    task automatic step(bit we, bit sel, int idx, longint data,
                        longint byte_addr, int kind, int priv, string tag);
        logic [2:0] exp, act;
        @(negedge clk);
        wr_en    = we;
        wr_sel   = sel;
        wr_idx   = IDX_W'(idx);
        wr_data  = AR_W'(data);
        acc_word = AR_W'(byte_addr >> 2);
        acc_kind = 2'(kind);
        acc_priv = 2'(priv);
        #2;
        exp = model(byte_addr >> 2, kind, priv);
        act = {fault_store, fault_load, fault_fetch};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: faults{store,load,fetch} actual=%b expected=%b", tag, act, exp);
        end
        @(posedge clk);
        if (we && rst_n && m_cfg[idx][7] == 1'b0) begin
            if (sel) m_addr[idx] = data & ((longint'(1) << AR_W) - 1);
            else     m_cfg[idx]  = int'(data) & 8'h9F;
        end
    endtask

    task automatic wcfg(int idx, int b, string tag);
        step(1, 0, idx, b, 0, IDLE, PM, tag);
    endtask

    task automatic waddr(int idx, longint w, string tag);
        step(1, 1, idx, w, 0, IDLE, PM, tag);
    endtask

    task automatic acc(longint a, int kind, int priv, string tag);
        step(0, 0, 0, 0, a, kind, priv, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=run complete");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();

        // reset state
        acc(32'h0000_1000, LOAD,  PU, "R1 user load after reset");
        acc(32'h0000_1000, FETCH, PS, "R1 supervisor fetch after reset");
        acc(32'h0000_1000, STORE, PM, "R1 machine store after reset");

        // single-word region, read only
        waddr(0, 32'h1000 >> 2, "R2 address write");
        wcfg(0, M_WORD | CR, "R2 cfg write");
        acc(32'h0000_1000, LOAD,  PU, "R4 word region load");
        acc(32'h0000_1000, STORE, PU, "R11 store needs write");
        acc(32'h0000_1000, FETCH, PU, "R11 fetch needs execute");
        acc(32'h0000_1004, LOAD,  PU, "R4 next word outside");
        acc(32'h0000_1000, IDLE,  PU, "R11 idle kind");

        // spare mode matches nothing
        waddr(1, 32'h2000 >> 2, "R2 address write r1");
        wcfg(1, M_SPARE | CR | CW | CX, "R3 spare mode cfg");
        acc(32'h0000_2000, LOAD, PU, "R4 spare mode no match");

        // power-of-two region 0x4000..0x43FF, read+execute, spare bits set
        waddr(2, (32'h4000 >> 2) | 32'h7F, "R2 address write r2");
        wcfg(2, 8'h60 | M_POW2 | CR | CX, "R3 bits 6,5 ignored");
        acc(32'h0000_4000, LOAD,  PS, "R5 pow2 base");
        acc(32'h0000_43FC, FETCH, PS, "R5 pow2 top word");
        acc(32'h0000_4400, LOAD,  PS, "R5 pow2 just above");
        acc(32'h0000_3FFC, LOAD,  PS, "R5 pow2 just below");
        acc(32'h0000_4000, STORE, PS, "R3 write bit clear");

        // overlapping region 0x4000..0x4FFF read+write
        waddr(3, (32'h4000 >> 2) | 32'h1FF, "R2 address write r3");
        wcfg(3, M_POW2 | CR | CW, "R3 cfg r3");
        acc(32'h0000_4100, STORE, PU, "R6 lower index decides");
        acc(32'h0000_4800, STORE, PU, "R6 only higher index matches");
        acc(32'h0000_4800, FETCH, PU, "R6 higher index no execute");

        // machine level
        acc(32'h0000_1000, STORE, PM, "R8 machine unlocked region");
        acc(32'h0000_9000, FETCH, PM, "R8 machine no match");
        acc(32'h0000_9000, LOAD,  PH, "R7 priv 2 as supervisor");

        // lock region 0
        wcfg(0, CLOCK | M_WORD | CR, "R9 lock write");
        acc(32'h0000_1000, STORE, PM, "R9 locked store at machine");
        acc(32'h0000_1000, LOAD,  PM, "R9 locked load at machine");
        acc(32'h0000_1000, FETCH, PM, "R9 locked fetch at machine");
        wcfg(0, M_POW2 | CR | CW | CX, "R10 cfg write to locked");
        acc(32'h0000_1000, STORE, PM, "R10 cfg unchanged");
        waddr(0, 32'h8000 >> 2, "R10 addr write to locked");
        acc(32'h0000_1000, LOAD, PU, "R10 addr unchanged");
        acc(32'h0000_8000, LOAD, PU, "R10 new addr not taken");

        // same-cycle response
        acc(32'h0000_4000, LOAD, PU, "R12 grant this cycle");
        acc(32'h0000_9000, LOAD, PU, "R12 refuse next cycle");

        // reset releases the lock
        do_reset();
        acc(32'h0000_1000, STORE, PM, "R1 lock cleared by reset");
        acc(32'h0000_4000, LOAD,  PU, "R1 table cleared by reset");

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r    = int'($urandom % 8);
            int idx  = int'($urandom % NREG);
            int kind = int'($urandom % 4);
            int priv = int'($urandom % 4);
            longint a = longint'($urandom & 32'hFFFC);
            if (i == 1500) do_reset();
            if (r == 0) begin
                int b = int'($urandom & 8'h7F);
                if ($urandom % 16 == 0) b = b | CLOCK;
                step(1, 0, idx, b, a, kind, priv, "R3 R10 random cfg");
            end else if (r == 1) begin
                int t = int'($urandom % 10);
                longint ones = (longint'(1) << t) - 1;
                longint w = (longint'($urandom & 32'h3FFF) & ~ones) | ones;
                step(1, 1, idx, w, a, kind, priv, "R5 R2 random addr");
            end else begin
                step(0, 0, 0, 0, a, kind, priv, "R6 R7 R8 random access");
            end
        end

        finish_run();
    end

endmodule